// File: doc/BRIEF.md
# Wide-Word Shift and Byte-Extract Unit

This unit performs four bit-level operations on 256-bit stack words: shift left, logical shift right, arithmetic shift right, and single-byte extraction counted from the most significant end. Each issued operation takes two words. The first is the top of the stack, used as the shift amount or byte index. The second is the value being operated on. A 2-bit select picks the operation. The select encoding follows the order of the opcodes in the range 0x1A to 0x1D, so the select equals the opcode minus 0x1A.

The unit takes one operation per clock and returns a registered result one cycle later. It can accept a new operation in every cycle. The full 256-bit shift amount is taken into account. Any amount of 256 or more gives a defined saturated result. This holds even when the only non-zero bits of the amount are high bits that a narrow shifter would ignore.

Top module: `wordshift_unit`

## Requirements
- R1: While rst_ni is low, and after it is released with no operation issued, res_o is zero and done_o is low.
- R2: An operation presented with start_i high at a rising edge gives done_o high and its result on res_o after that same edge. Operations may be issued on consecutive cycles, and each result follows its own operands.
- R3: With op_i = 0 (opcode 0x1A, byte extract) and an index below 32, res_o[7:0] holds byte number index of val_i. Index 0 is val_i[255:248] and index 31 is val_i[7:0]. res_o[255:8] is zero.
- R4: With op_i = 0 and an index of 32 or more in any bit of amt_i, res_o is zero.
- R5: With op_i = 1 (opcode 0x1B, shift left) and amt_i below 256, res_o is val_i shifted left by amt_i. Zeros enter from the bottom, and bits pushed past bit 255 are lost.
- R6: With op_i = 2 (opcode 0x1C, logical shift right) and amt_i below 256, res_o is val_i shifted right with zeros entering at the top. A shift by 224 leaves the top 4 bytes of val_i in res_o[31:0].
- R7: With op_i = 3 (opcode 0x1D, arithmetic shift right) and amt_i below 256, the vacated top bits are copies of val_i[255]. For example, all ones except bit 0 (minus two), shifted by 1, gives all ones.
- R8: When amt_i is 256 or more, shift left and logical shift right give zero. Arithmetic shift right gives all ones if val_i[255] is 1 and zero otherwise. The same holds when the only set bits of amt_i lie above bit 8.
- R9: A shift amount of zero returns val_i unchanged for all three shifts.
- R10: With start_i low, the operand and select inputs are ignored. res_o keeps its last value and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue an operation this cycle |
| op_i | input | 2 | Operation select: 0 byte, 1 shl, 2 shr, 3 sar |
| amt_i | input | 256 | Top-of-stack word: shift amount or byte index |
| val_i | input | 256 | Second stack word: value operated on |
| res_o | output | 256 | Registered result |
| done_o | output | 1 | Result on res_o was produced by the previous edge |

## Verification
Two conditions can meet in one cycle: saturation of an oversized amount and the sign fill of the arithmetic shift. The bench provokes this by issuing arithmetic shifts with amounts of 256, with amounts whose only set bit is far above bit 8, and with negative and non-negative values. It judges the result against an all-ones or all-zeros word chosen from the value's top bit. A second overlap is back-to-back issue, where the result of one operation is presented in the same cycle the next one is accepted. The bench issues streams of operations with no gap and checks each result in the cycle after its own operands, against a reference model built from the requirements.

// File: rtl/wsu_pkg.sv
package wsu_pkg;
  typedef enum logic [1:0] {
    OP_BYTE = 2'd0,
    OP_SHL  = 2'd1,
    OP_SHR  = 2'd2,
    OP_SAR  = 2'd3
  } wsu_op_e;
endpackage

// File: rtl/wsu_amt_dec.sv
module wsu_amt_dec #(
  parameter int W      = 256,
  parameter int BYTE_W = 8
) (
  input  logic [W-1:0]             amt_i,
  output logic [$clog2(W)-1:0]     sh_o,
  output logic                     sat_o,
  output logic [$clog2(W/BYTE_W)-1:0] idx_o,
  output logic                     idx_oob_o
);
  localparam int SH_W  = $clog2(W);
  localparam int IDX_W = $clog2(W / BYTE_W);

  assign sh_o      = amt_i[SH_W-1:0];
  // any bit at or above W counts, not just the low byte
  assign sat_o     = |amt_i[W-1:SH_W];
  assign idx_o     = amt_i[IDX_W-1:0];
  assign idx_oob_o = |amt_i[W-1:IDX_W];
endmodule

// File: rtl/wsu_barrel.sv
module wsu_barrel #(
  parameter int W = 256
) (
  input  logic [W-1:0]         val_i,
  input  logic [$clog2(W)-1:0] sh_i,
  input  logic                 left_i,
  input  logic                 arith_i,
  output logic [W-1:0]         res_o
);
  localparam int SH_W = $clog2(W);

  logic [W-1:0] rev_in, rev_out;
  logic [W-1:0] stage [SH_W+1];
  logic         fill;

  // left shift = reverse, right shift, reverse
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = val_i[W-1-i];
    assign rev_out[i] = stage[SH_W][W-1-i];
  end

  assign fill     = arith_i & ~left_i & val_i[W-1];
  assign stage[0] = left_i ? rev_in : val_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stage[k+1] = sh_i[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
  end

  assign res_o = left_i ? rev_out : stage[SH_W];
endmodule

// File: rtl/wsu_byte_pick.sv
module wsu_byte_pick #(
  parameter int W      = 256,
  parameter int BYTE_W = 8
) (
  input  logic [W-1:0]                val_i,
  input  logic [$clog2(W/BYTE_W)-1:0] idx_i,
  input  logic                        oob_i,
  output logic [W-1:0]                res_o
);
  localparam int NB    = W / BYTE_W;
  localparam int IDX_W = $clog2(NB);

  logic [BYTE_W-1:0] sel;

  // index 0 is the most significant byte
  always_comb begin
    sel = '0;
    for (int b = 0; b < NB; b++) begin
      if (idx_i == IDX_W'(b)) sel = val_i[W-1-b*BYTE_W -: BYTE_W];
    end
  end

  assign res_o = oob_i ? '0 : {{(W-BYTE_W){1'b0}}, sel};
endmodule

// File: rtl/wordshift_unit.sv
module wordshift_unit
  import wsu_pkg::*;
#(
  parameter int W      = 256,
  parameter int BYTE_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] amt_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] res_o,
  output logic         done_o
);
  localparam int SH_W  = $clog2(W);
  localparam int IDX_W = $clog2(W / BYTE_W);

  wsu_op_e          op;
  logic [SH_W-1:0]  sh;
  logic             sat;
  logic [IDX_W-1:0] idx;
  logic             idx_oob;
  logic [W-1:0]     shf_res, byte_res, nxt;

  assign op = wsu_op_e'(op_i);

  wsu_amt_dec #(.W(W), .BYTE_W(BYTE_W)) dec_i (
    .amt_i(amt_i), .sh_o(sh), .sat_o(sat), .idx_o(idx), .idx_oob_o(idx_oob)
  );

  wsu_barrel #(.W(W)) bsh_i (
    .val_i(val_i), .sh_i(sh), .left_i(op == OP_SHL), .arith_i(op == OP_SAR),
    .res_o(shf_res)
  );

  wsu_byte_pick #(.W(W), .BYTE_W(BYTE_W)) bpk_i (
    .val_i(val_i), .idx_i(idx), .oob_i(idx_oob), .res_o(byte_res)
  );

  always_comb begin
    unique case (op)
      OP_BYTE: nxt = byte_res;
      OP_SAR:  nxt = sat ? {W{val_i[W-1]}} : shf_res;
      default: nxt = sat ? '0 : shf_res;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) res_o <= nxt;
    end
  end
endmodule

// File: rtl/wsu_checker.sv
module wsu_checker #(
  parameter int W = 256
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] amt_i,
  input logic [W-1:0] val_i,
  input logic [W-1:0] res_o,
  input logic         done_o
);
  // R2
  done_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!done_o && $stable(res_o)));
  // R3
  byte_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 2'd0) |=> (res_o[W-1:8] == '0));
  // R4
  byte_oob_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 2'd0 && |amt_i[W-1:5]) |=> (res_o == '0));
  // R8
  sat_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (op_i == 2'd1 || op_i == 2'd2) && |amt_i[W-1:8]) |=> (res_o == '0));
  // R8
  sat_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 2'd3 && |amt_i[W-1:8]) |=> (res_o == {W{$past(val_i[W-1])}}));
  // R9
  zero_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i != 2'd0 && amt_i == '0) |=> (res_o == $past(val_i)));
endmodule

bind wordshift_unit wsu_checker #(.W(W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .amt_i(amt_i), .val_i(val_i), .res_o(res_o), .done_o(done_o)
);

// File: tb/wordshift_unit_tb_top.sv
`timescale 1ns/1ps
module wordshift_unit_tb_top;
  localparam int W = 256;
  localparam int NV = 13;
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] TOP1 = {1'b1, {(W-1){1'b0}}};

  localparam logic [1:0]   T_OP  [NV] = '{2, 3, 0, 0, 0, 1, 2, 1, 3, 2, 1, 3, 3};
  localparam int           T_REQ [NV] = '{6, 7, 3, 3, 4, 5, 6, 5, 8, 8, 8, 9, 7};
  localparam logic [W-1:0] T_AMT [NV] = '{
    W'(224), W'(1), W'(0), W'(31), W'(32), W'(8), W'(8), W'(255),
    W'(256), W'(256), TOP1 >> 55, W'(0), W'(255)};
  localparam logic [W-1:0] T_VAL [NV] = '{
    (W'(32'h1234_5678) << 224) | W'(64'hdead_beef_cafe_f00d), // R6
    ONES ^ W'(1),                                             // R7
    W'(8'hFF) << 248,                                         // R3
    W'(8'hAB) | (W'(8'h77) << 8),                             // R3
    ONES,                                                     // R4
    W'(1),                                                    // R5
    W'(256),                                                  // R6
    W'(3),                                                    // R5
    TOP1,                                                     // R8
    ONES,                                                     // R8
    ONES,                                                     // R8
    TOP1 | W'(5),                                             // R9
    ONES >> 1};                                               // R7
  localparam logic [W-1:0] T_EXP [NV] = '{
    W'(32'h1234_5678), ONES, W'(8'hFF), W'(8'hAB), '0, W'(256), W'(1),
    TOP1, ONES, '0, '0, TOP1 | W'(5), '0};

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] op = 0;
  logic [W-1:0] amt = '0, val = '0;
  logic [W-1:0] res;
  logic done;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wordshift_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .amt_i(amt), .val_i(val), .res_o(res), .done_o(done)
  );

  function automatic logic [W-1:0] model(logic [1:0] o, logic [W-1:0] a, logic [W-1:0] v);
    logic big = |a[W-1:8];
    case (o)
      2'd0: return (a < 32) ? ((v >> (8 * (31 - int'(a[4:0])))) & W'(8'hFF)) : '0;
      2'd1: return big ? '0 : v << a[7:0];
      2'd2: return big ? '0 : v >> a[7:0];
      default: return big ? {W{v[W-1]}} : W'($signed(v) >>> a[7:0]);
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] r;
    for (int i = 0; i < W / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // issue at negedge, look after the next rising edge; start stays high for back-to-back
  task automatic issue(logic [1:0] o, logic [W-1:0] a, logic [W-1:0] v,
                       logic [W-1:0] exp, string tag);
    @(negedge clk);
    start = 1; op = o; amt = a; val = v;
    @(posedge clk); #1;
    check(tag, res, exp);
    check({tag, " R2 done"}, {{(W-1){1'b0}}, done}, W'(1));
  endtask

  task automatic finish_up();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R2 got=hung exp=done");
      finish_up();
    end
  end

  initial begin
    // R1
    #20;
    check("R1 res in reset", res, '0);
    check("R1 done in reset", W'(done), '0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 res after release", res, '0);

    // table, issued back-to-back (R2)
    for (int i = 0; i < NV; i++) begin
      issue(T_OP[i], T_AMT[i], T_VAL[i], T_EXP[i], $sformatf("R%0d vec%0d", T_REQ[i], i));
    end

    // R10: idle inputs change, output held
    @(negedge clk);
    start = 0; op = 2'd1; amt = W'(3); val = ONES;
    @(posedge clk); #1;
    check("R10 done low", W'(done), '0);
    @(posedge clk); #1;
    check("R10 res held", res, T_EXP[NV-1]);

    // R8: saturation meets sign fill
    issue(2'd3, TOP1, ONES ^ W'(7), ONES, "R8 sar huge neg");
    issue(2'd3, W'(1) << 100, W'(12345), '0, "R8 sar huge pos");
    issue(2'd2, W'(1) << 9, ONES, '0, "R8 shr upper only");
    issue(2'd0, W'(1) << 200, ONES, '0, "R4 byte upper only");
    issue(2'd0, W'(33), ONES, '0, "R4 byte 33");

    // R9 zero shift, each shift op
    for (int o = 1; o < 4; o++) begin
      logic [W-1:0] v = rnd();
      issue(2'(o), '0, v, v, "R9 zero amt");
    end

    // R3 every byte index
    for (int b = 0; b < 32; b++) begin
      logic [W-1:0] v = rnd();
      issue(2'd0, W'(b), v, W'(v[255 - 8*b -: 8]), "R3 byte index");
    end

    // random operands, amounts at edges (R5 R6 R7 R8)
    for (int i = 0; i < 240; i++) begin
      logic [W-1:0] v = rnd();
      logic [W-1:0] a;
      logic [1:0] o = 2'($urandom_range(0, 3));
      case (i % 6)
        0: a = W'(1);
        1: a = W'(255);
        2: a = W'(256);
        3: a = rnd();
        4: a = W'($urandom_range(0, 40));
        default: a = W'($urandom_range(0, 255));
      endcase
      issue(o, a, v, model(o, a, v), $sformatf("R%0d random op%0d", 5 + int'(o == 2) + 2*int'(o == 3) - 2*int'(o == 0), o));
    end

    @(negedge clk); start = 0;
    @(posedge clk); #1;
    check("R10 done drops", W'(done), '0);
    finish_up();
  end
endmodule